// File: doc/BRIEF.md
# Cascaded Dual Priority Interrupt Controller

This block merges fifteen interrupt request lines into one CPU interrupt output. It does this with two eight-input priority units. The second unit (the slave) drives input 2 of the first unit (the master), so every slave line ranks below master lines 0 and 1 and above master lines 3 to 7. Software sets up each unit through a byte-wide write port. A setup sequence of up to four words sets the vector base. After setup, data writes load the mask, and command writes issue non-specific end-of-interrupt.

The CPU answers the interrupt with a one-cycle acknowledge strobe. One cycle later the block returns the 8-bit vector of the winning request and records that request as in service. A request stays blocked at its own priority and below until software clears it with end-of-interrupt. For a slave line, software writes end-of-interrupt to the slave first and then to the master.

Top module: `cascadedPic`

## Requirements
- R1: After reset, `intOut` is low, both masks are all ones (every line disabled), no request is pending and both vector bases are zero.
- R2: A write with `wrA0`=0 and data bit 4 = 1 starts a unit's setup sequence. The next `wrA0`=1 write loads the vector base from data bits 7:3. A third word follows only when bit 1 of the first word was 0. A fourth word follows only when bit 0 of the first word was 1. Every later `wrA0`=1 write loads the mask.
- R3: A mask bit of 1 stops its line from raising `intOut`. The request stays latched while masked and is delivered once its mask bit is cleared.
- R4: A user line is latched on a rising edge and the latch clears when the line falls. A line held high after its acknowledge does not request again.
- R5: The merged priority order from highest to lowest is lines 0, 1, 8 to 15, 3 to 7. An acknowledge serves the highest eligible line.
- R6: The vector for a master line n is the master base (bits 7:3) plus n. The vector for a slave line 8+k is the slave base (bits 7:3) plus k.
- R7: An acknowledge sets the in-service bit of the served line. While any line is in service, only lines of strictly higher priority can raise `intOut`.
- R8: A write with `wrA0`=0, data bits 7:5 = 001 and bits 4:3 = 00 is a non-specific end-of-interrupt. It clears the highest-priority in-service bit of the addressed unit. A slave line remains blocked at the master until the master also receives end-of-interrupt.
- R9: An acknowledge with no eligible request returns master base + 7 and sets no in-service bit.
- R10: The first setup word clears the unit's pending and in-service state and sets its mask to all ones.
- R11: `vecValid` is high for exactly the one cycle after an `ackIn` cycle, with `vecOut` holding the vector.
- R12: Port `reqIn` carries lines 0 and 1 on bits 1:0, lines 3 to 7 on bits 6:2 and lines 8 to 15 on bits 14:7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqIn | input | 15 | Request lines, packed as in R12 |
| wrEn | input | 1 | Register write strobe |
| wrSlave | input | 1 | 1 addresses the slave unit, 0 the master unit |
| wrA0 | input | 1 | Register select: 0 for setup start and commands, 1 for data |
| wrData | input | 8 | Write data |
| ackIn | input | 1 | Interrupt acknowledge strobe |
| intOut | output | 1 | Interrupt request to the CPU |
| vecValid | output | 1 | Vector valid, one cycle after acknowledge |
| vecOut | output | 8 | Acknowledged vector |

## Verification
The bench raises several lines at once, from both units, and follows the acknowledges through the merged order. A design that ranked the slave by its own input numbers, or placed it below master line 3, returns the wrong vectors. Nesting tests check two things. A lower line must stay silent under a higher in-service line. A slave line must stay blocked after only the slave's end-of-interrupt, and a design that cleared the wrong unit's in-service bit raises `intOut` too early or never. A request that drops before its acknowledge must return the spurious vector and leave nothing in service. A setup sequence that skips the third word must not take the mask write as a setup word. Re-running setup must leave no stale in-service bit that would block a later line.

// File: rtl/picPkg.sv
package picPkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    S_READY,
    S_WORD2,
    S_WORD3,
    S_WORD4
  } initStateT;

  typedef struct packed {
    logic              initClr;
    logic              baseLd;
    logic              maskLd;
    logic              eoi;
    logic [DATA_W-1:0] data;
  } picStrobeT;
endpackage

// File: rtl/picCtrl.sv
module picCtrl
  import picPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrA0,
  input  logic [DATA_W-1:0] wrData,
  output picStrobeT         strb
);
  initStateT state;
  logic      needWord4;
  logic      skipWord3;
  logic      isWord1;
  logic      isCmd;

  assign isWord1 = wrEn & ~wrA0 & wrData[4];
  assign isCmd   = wrEn & ~wrA0 & ~wrData[4] & ~wrData[3];

  always_comb begin
    strb.initClr = isWord1;
    strb.eoi     = isCmd & (wrData[7:5] == 3'b001);
    strb.baseLd  = wrEn & wrA0 & (state == S_WORD2);
    strb.maskLd  = wrEn & wrA0 & (state == S_READY);
    strb.data    = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_READY;
      needWord4 <= 1'b0;
      skipWord3 <= 1'b0;
    end else if (isWord1) begin
      state     <= S_WORD2;
      needWord4 <= wrData[0];
      skipWord3 <= wrData[1];
    end else if (wrEn && wrA0) begin
      unique case (state)
        S_WORD2: state <= skipWord3 ? (needWord4 ? S_WORD4 : S_READY) : S_WORD3;
        S_WORD3: state <= needWord4 ? S_WORD4 : S_READY;
        S_WORD4: state <= S_READY;
        default: state <= S_READY;
      endcase
    end
  end

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.initClr, strb.baseLd, strb.maskLd, strb.eoi}));

  p_word1_restarts_r2: assert property (@(posedge clk) disable iff (!rstN)
    isWord1 |=> (state == S_WORD2));
endmodule

// File: rtl/picCore.sv
module picCore
  import picPkg::*;
#(
  parameter int                NUM_IN     = 8,
  parameter logic [NUM_IN-1:0] LEVEL_MASK = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  picStrobeT                strb,
  input  logic [NUM_IN-1:0]        reqIn,
  input  logic                     ackTake,
  output logic                     intOut,
  output logic                     pickValid,
  output logic [$clog2(NUM_IN)-1:0] pickIdx,
  output logic [DATA_W-$clog2(NUM_IN)-1:0] base
);
  localparam int IDX_W  = $clog2(NUM_IN);
  localparam int BASE_W = DATA_W - IDX_W;

  logic [NUM_IN-1:0] irr, imr, isr, prevReq;
  logic [NUM_IN-1:0] rising, pend, above, eligible, ackBit, eoiBit;
  logic [BASE_W-1:0] baseR;

  assign rising   = reqIn & ~prevReq & ~LEVEL_MASK;
  assign pend     = (irr | (reqIn & LEVEL_MASK)) & ~imr;
  assign eligible = pend & above;
  assign eoiBit   = strb.eoi ? (isr & (~isr + 1'b1)) : '0;
  assign ackBit   = ackTake ? (NUM_IN'(1) << pickIdx) : '0;

  always_comb begin
    logic seen;
    seen  = 1'b0;
    above = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (isr[i]) seen = 1'b1;
      if (!seen) above[i] = 1'b1;
    end
  end

  always_comb begin
    pickIdx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (eligible[i]) pickIdx = IDX_W'(i);
    end
  end

  assign pickValid = |eligible;
  assign intOut    = pickValid;
  assign base      = baseR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irr     <= '0;
      imr     <= '1;
      isr     <= '0;
      prevReq <= '0;
      baseR   <= '0;
    end else begin
      prevReq <= reqIn;
      if (strb.initClr) begin
        irr <= '0;
        isr <= '0;
        imr <= '1;
      end else begin
        irr <= (irr | rising) & reqIn & ~ackBit;
        isr <= (isr | ackBit) & ~eoiBit;
        if (strb.maskLd) imr <= strb.data;
      end
      if (strb.baseLd) baseR <= strb.data[DATA_W-1:IDX_W];
    end
  end

  p_ack_sets_isr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackTake && !strb.initClr && !strb.eoi) |=>
      ($countones(isr) == $countones($past(isr)) + 1));

  p_eoi_clears_one_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoi && (isr != '0) && !ackTake && !strb.initClr) |=>
      ($countones(isr) + 1 == $countones($past(isr))));

  p_init_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.initClr |=> ((isr == '0) && (irr == '0) && (imr == '1)));
endmodule

// File: rtl/cascadedPic.sv
module cascadedPic
  import picPkg::*;
#(
  parameter int CASCADE_IN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [14:0]       reqIn,
  input  logic              wrEn,
  input  logic              wrSlave,
  input  logic              wrA0,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ackIn,
  output logic              intOut,
  output logic              vecValid,
  output logic [DATA_W-1:0] vecOut
);
  localparam int NUM_IN = 8;
  localparam int IDX_W  = $clog2(NUM_IN);
  localparam int BASE_W = DATA_W - IDX_W;

  picStrobeT         strbArr  [2];
  logic [NUM_IN-1:0] unitReq  [2];
  logic              intArr   [2];
  logic              validArr [2];
  logic [IDX_W-1:0]  idxArr   [2];
  logic [BASE_W-1:0] baseArr  [2];
  logic [1:0]        ackTake;
  logic [DATA_W-1:0] vecNext;

  assign unitReq[0] = {reqIn[6:2], intArr[1], reqIn[1:0]};
  assign unitReq[1] = reqIn[14:7];

  for (genvar u = 0; u < 2; u++) begin : g_unit
    localparam logic [NUM_IN-1:0] LVL = (u == 0) ? (NUM_IN'(1) << CASCADE_IN) : '0;

    picCtrl uCtrl (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (wrEn & (wrSlave == 1'(u))),
      .wrA0   (wrA0),
      .wrData (wrData),
      .strb   (strbArr[u])
    );

    picCore #(.NUM_IN(NUM_IN), .LEVEL_MASK(LVL)) uCore (
      .clk       (clk),
      .rstN      (rstN),
      .strb      (strbArr[u]),
      .reqIn     (unitReq[u]),
      .ackTake   (ackTake[u]),
      .intOut    (intArr[u]),
      .pickValid (validArr[u]),
      .pickIdx   (idxArr[u]),
      .base      (baseArr[u])
    );
  end

  assign ackTake[0] = ackIn & validArr[0];
  assign ackTake[1] = ackIn & validArr[0] & (idxArr[0] == IDX_W'(CASCADE_IN));
  assign intOut     = intArr[0];

  always_comb begin
    if (!validArr[0])                           vecNext = {baseArr[0], {IDX_W{1'b1}}};
    else if (idxArr[0] == IDX_W'(CASCADE_IN))   vecNext = {baseArr[1], idxArr[1]};
    else                                        vecNext = {baseArr[0], idxArr[0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else begin
      vecValid <= ackIn;
      if (ackIn) vecOut <= vecNext;
    end
  end

  p_vec_follows_ack_r11: assert property (@(posedge clk) disable iff (!rstN)
    ackIn |=> vecValid);

  p_vec_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    !ackIn |=> !vecValid);

  p_slave_via_master_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackTake[1] |-> (ackTake[0] && validArr[1]));
endmodule

// File: tb/cascadedPic_test.sv
module cascadedPic_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] reqIn = '0;
  logic        wrEn = 1'b0, wrSlave = 1'b0, wrA0 = 1'b0;
  logic [7:0]  wrData = '0;
  logic        ackIn = 1'b0;
  logic        intOut, vecValid;
  logic [7:0]  vecOut;
  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  cascadedPic uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .wrEn(wrEn), .wrSlave(wrSlave),
    .wrA0(wrA0), .wrData(wrData), .ackIn(ackIn), .intOut(intOut),
    .vecValid(vecValid), .vecOut(vecOut)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R12 packing of line numbers onto reqIn bits
  function automatic int bitOf(input int line);
    return (line < 2) ? line : line - 1;
  endfunction

  task automatic wr(input logic slave, input logic a0, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSlave = slave; wrA0 = a0; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setLine(input int line, input logic v);
    @(negedge clk);
    reqIn[bitOf(line)] = v;
    @(negedge clk);
  endtask

  task automatic ack(input string tag, input logic [7:0] exp);
    @(negedge clk);
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
    chk({tag, " R11 valid"}, 8'(vecValid), 8'h1);
    chk(tag, vecOut, exp);
    @(negedge clk);
    chk({tag, " R11 pulse"}, 8'(vecValid), 8'h0);
  endtask

  task automatic eoiM(); wr(1'b0, 1'b0, 8'h20); endtask
  task automatic eoiS(); wr(1'b1, 1'b0, 8'h20); endtask

  task automatic setup(input logic [7:0] mBase);
    wr(1'b0, 1'b0, 8'h11); wr(1'b0, 1'b1, mBase); wr(1'b0, 1'b1, 8'h04); wr(1'b0, 1'b1, 8'h01);
    wr(1'b1, 1'b0, 8'h11); wr(1'b1, 1'b1, mBase + 8'd8); wr(1'b1, 1'b1, 8'h02); wr(1'b1, 1'b1, 8'h01);
  endtask

  task automatic testReset();
    chk("R1 intOut after reset", 8'(intOut), 8'h0);
    setLine(0, 1'b1);
    chk("R1 masked after reset", 8'(intOut), 8'h0);
    setLine(0, 1'b0);
    ack("R1 zero base spurious", 8'h07);
  endtask

  task automatic testInitMask();
    setup(8'h40);
    wr(1'b0, 1'b1, 8'hFB);
    wr(1'b1, 1'b1, 8'hFF);
    ack("R2 R9 spurious after setup", 8'h47);
    setLine(3, 1'b1);
    chk("R3 masked line quiet", 8'(intOut), 8'h0);
    wr(1'b0, 1'b1, 8'hF3);
    chk("R3 latched then delivered", 8'(intOut), 8'h1);
    ack("R6 master line 3", 8'h43);
    eoiM();
    chk("R4 held line no retrigger", 8'(intOut), 8'h0);
    setLine(3, 1'b0);
  endtask

  task automatic testPriority();
    wr(1'b0, 1'b1, 8'h00);
    wr(1'b1, 1'b1, 8'h00);
    setLine(5, 1'b1); setLine(12, 1'b1); setLine(1, 1'b1);
    ack("R5 line 1 first", 8'h41);
    eoiM();
    ack("R5 R6 slave line 12 next", 8'h4C);
    eoiS(); eoiM();
    ack("R5 line 5 last", 8'h45);
    eoiM();
    chk("R5 nothing left", 8'(intOut), 8'h0);
    setLine(5, 1'b0); setLine(12, 1'b0); setLine(1, 1'b0);
  endtask

  task automatic testNesting();
    setLine(4, 1'b1);
    ack("R7 line 4", 8'h44);
    setLine(6, 1'b1);
    chk("R7 lower line blocked", 8'(intOut), 8'h0);
    setLine(9, 1'b1);
    chk("R7 higher slave line passes", 8'(intOut), 8'h1);
    ack("R7 line 9 nested", 8'h49);
    setLine(10, 1'b1);
    eoiS();
    chk("R8 slave eoi alone keeps block", 8'(intOut), 8'h0);
    eoiM();
    chk("R8 master eoi releases slave", 8'(intOut), 8'h1);
    ack("R8 line 10", 8'h4A);
    eoiS(); eoiM();
    chk("R8 line 4 still in service", 8'(intOut), 8'h0);
    eoiM();
    chk("R8 line 6 released", 8'(intOut), 8'h1);
    ack("R7 line 6", 8'h46);
    eoiM();
    setLine(4, 1'b0); setLine(6, 1'b0); setLine(9, 1'b0); setLine(10, 1'b0);
  endtask

  task automatic testSpurious();
    setLine(13, 1'b1);
    chk("R4 slave line raises", 8'(intOut), 8'h1);
    setLine(13, 1'b0);
    chk("R4 drop clears request", 8'(intOut), 8'h0);
    ack("R9 dropped request", 8'h47);
    setLine(7, 1'b1);
    chk("R9 no in-service left", 8'(intOut), 8'h1);
    ack("R9 real line 7", 8'h47);
    eoiM();
    setLine(7, 1'b0);
  endtask

  task automatic testReinit();
    setLine(0, 1'b1);
    ack("R10 line 0", 8'h40);
    wr(1'b0, 1'b0, 8'h13); wr(1'b0, 1'b1, 8'h80); wr(1'b0, 1'b1, 8'h01);
    setLine(1, 1'b1);
    chk("R10 mask all ones", 8'(intOut), 8'h0);
    wr(1'b0, 1'b1, 8'h00);
    chk("R2 R10 mask write after skip", 8'(intOut), 8'h1);
    ack("R2 new base", 8'h81);
    eoiM();
    chk("R4 line 0 no new edge", 8'(intOut), 8'h0);
  endtask

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInitMask();
    testPriority();
    testNesting();
    testSpurious();
    testReinit();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule